// File: doc/BRIEF.md
# Result Signature Monitor with Crash Timeout

This block watches the parallel output port of a system under test. Once per program cycle the system under test places a result signature on the port and raises a write strobe. The monitor synchronizes the strobe, captures the port value on its rising edge and compares it with an expected value that was loaded ahead of time. Each program cycle is sorted into one of three outcomes. A matching value is correct. A differing value is a wrong result that escaped, which is a fail-silent violation. If no signature arrives before a programmable window expires, the cycle is a crash.

A start pulse arms the monitor, clears its three outcome counters and opens the first window. Every judged or timed-out cycle produces a one-cycle outcome pulse with a 2-bit code. The matching saturating counter advances at the same clock edge. After a crash the window stays closed, so a dead target is reported once and not over and over. The next strobe that arrives reopens the window.

Top module: `result_sig_monitor`

## Requirements
- R1: After reset, outValid and outCode are 0, all three counters are 0, and armed and waiting are 0.
- R2: A start pulse sets armed, clears all counters and waiting, and restarts the timeout window. Strobes seen before the first start pulse produce no outcome pulse and change no counter.
- R3: When portStrobe rises and stays high for at least 3 clock cycles, outValid is high for exactly one cycle. This pulse is visible after the third rising clock edge that samples the strobe high, and lastSig then holds the portData value captured at that edge.
- R4: A captured value equal to the expected value gives outCode 2'b01 and increments cntCorrect.
- R5: A captured value that differs from the expected value in any bit gives outCode 2'b10 and increments cntViol.
- R6: With a timeoutLimit of L (at least 1), when no strobe is captured for L clock cycles after the edge that took the start pulse or the last captured strobe, one pulse with outCode 2'b11 appears and cntCrash increments.
- R7: After a crash pulse, waiting is 1 and no further crash pulse occurs until a strobe is captured. That strobe is judged normally, clears waiting and reopens the window.
- R8: Each counter is CNT_W bits wide and saturates at its all-ones value.
- R9: A value written with expLoad is used for every strobe captured after the loading edge, and the previous expected value no longer matches.
- R10: outCode is 2'b00 whenever outValid is low.
- R11: If a strobe is captured at the same edge at which the window would expire, the capture wins: the cycle is judged and no crash is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Arms the monitor, clears the counters, restarts the window |
| expLoad | input | 1 | Loads expValue as the expected signature |
| expValue | input | SIG_W | Expected signature |
| timeoutLimit | input | TO_W | Window length in clock cycles (nonzero) |
| portStrobe | input | 1 | Asynchronous write strobe from the target |
| portData | input | SIG_W | Signature on the target's output port |
| outValid | output | 1 | One-cycle outcome pulse |
| outCode | output | 2 | 01 correct, 10 violation, 11 crash, 00 idle |
| lastSig | output | SIG_W | Most recently captured signature |
| cntCorrect | output | CNT_W | Saturating count of correct cycles |
| cntViol | output | CNT_W | Saturating count of violations |
| cntCrash | output | CNT_W | Saturating count of crashes |
| armed | output | 1 | Monitor has been started |
| waiting | output | 1 | A crash was reported and the window is paused |

## Verification
The assertions assume that timeoutLimit is nonzero and held steady while the monitor is armed. They also assume that portData is stable from the strobe's rise until the capture edge. Finally, they assume the strobe stays high and then low for at least three clock cycles each, so that the synchronizer sees every edge. The bench changes timeoutLimit only just before a start pulse, and it sets the data at the same falling clock edge that raises the strobe. It holds the strobe high for four cycles and low for three, and it places strobes at exact offsets from the start edge to reach the window boundary from both sides.

// File: rtl/sigmon_pkg.sv
package sigmon_pkg;

  // Outcome codes presented on outCode
  typedef enum logic [1:0] {
    OC_NONE      = 2'b00,
    OC_CORRECT   = 2'b01,
    OC_VIOLATION = 2'b10,
    OC_CRASH     = 2'b11
  } outcome_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // start: clear counters and outcome
    logic judge;     // capture port data and compare
    logic crash;     // window expired with no capture
  } ctrlStrobes_t;

  localparam int NUM_OUTCOMES = 3;
  localparam int IDX_CORRECT  = 0;
  localparam int IDX_VIOL     = 1;
  localparam int IDX_CRASH    = 2;

endpackage

// File: rtl/sigmon_satcnt.sv
module sigmon_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic atMax;
  assign atMax = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && !atMax) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sigmon_ctrl.sv
module sigmon_ctrl
  import sigmon_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            portStrobe,
  input  logic [TO_W-1:0] timeoutLimit,
  output ctrlStrobes_t    strobes,
  output logic            armed,
  output logic            waiting
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  // Strobe synchronizer and rise detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   strobeDly;
  logic                   strobeRise;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= portStrobe;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_MSB-1:0], portStrobe};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeDly <= 1'b0;
    else       strobeDly <= syncQ[SYNC_MSB];
  end

  assign strobeRise = syncQ[SYNC_MSB] & ~strobeDly;

  // Timeout window
  logic [TO_W-1:0] windowCnt;
  logic            limitHit;

  assign limitHit = (windowCnt == (timeoutLimit - 1'b1));

  always_comb begin
    strobes          = '0;
    strobes.clearAll = startPulse;
    strobes.judge    = armed & ~startPulse & strobeRise;
    strobes.crash    = armed & ~startPulse & ~strobeRise & ~waiting & limitHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      waiting   <= 1'b0;
      windowCnt <= '0;
    end else if (startPulse) begin
      armed     <= 1'b1;
      waiting   <= 1'b0;
      windowCnt <= '0;
    end else if (armed) begin
      if (strobes.judge) begin
        waiting   <= 1'b0;
        windowCnt <= '0;
      end else if (strobes.crash) begin
        waiting   <= 1'b1;
      end else if (!waiting) begin
        windowCnt <= windowCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sigmon_dpath.sv
module sigmon_dpath
  import sigmon_pkg::*;
#(
  parameter int SIG_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [SIG_W-1:0] portData,
  input  logic             expLoad,
  input  logic [SIG_W-1:0] expValue,
  output logic             outValid,
  output logic [1:0]       outCode,
  output logic [SIG_W-1:0] lastSig,
  output logic [CNT_W-1:0] cntCorrect,
  output logic [CNT_W-1:0] cntViol,
  output logic [CNT_W-1:0] cntCrash
);

  logic [SIG_W-1:0] expReg;
  logic             sigMatch;
  outcome_e         nextCode;
  logic [NUM_OUTCOMES-1:0] bump;
  logic [NUM_OUTCOMES-1:0][CNT_W-1:0] cntArr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        expReg <= '0;
    else if (expLoad) expReg <= expValue;
  end

  assign sigMatch = (portData == expReg);

  always_comb begin
    nextCode = OC_NONE;
    if (strobes.judge)      nextCode = sigMatch ? OC_CORRECT : OC_VIOLATION;
    else if (strobes.crash) nextCode = OC_CRASH;
  end

  always_comb begin
    bump              = '0;
    bump[IDX_CORRECT] = !strobes.clearAll && (nextCode == OC_CORRECT);
    bump[IDX_VIOL]    = !strobes.clearAll && (nextCode == OC_VIOLATION);
    bump[IDX_CRASH]   = !strobes.clearAll && (nextCode == OC_CRASH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCode  <= OC_NONE;
      lastSig  <= '0;
    end else begin
      outValid <= !strobes.clearAll && (nextCode != OC_NONE);
      outCode  <= strobes.clearAll ? OC_NONE : nextCode;
      if (strobes.judge) lastSig <= portData;
    end
  end

  generate
    for (genvar g = 0; g < NUM_OUTCOMES; g++) begin : g_cnt
      sigmon_satcnt #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rstN (rstN),
        .clr  (strobes.clearAll),
        .inc  (bump[g]),
        .count(cntArr[g])
      );
    end
  endgenerate

  assign cntCorrect = cntArr[IDX_CORRECT];
  assign cntViol    = cntArr[IDX_VIOL];
  assign cntCrash   = cntArr[IDX_CRASH];

endmodule

// File: rtl/result_sig_monitor.sv
module result_sig_monitor
  import sigmon_pkg::*;
#(
  parameter int SIG_W = 16,
  parameter int TO_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             expLoad,
  input  logic [SIG_W-1:0] expValue,
  input  logic [TO_W-1:0]  timeoutLimit,
  input  logic             portStrobe,
  input  logic [SIG_W-1:0] portData,
  output logic             outValid,
  output logic [1:0]       outCode,
  output logic [SIG_W-1:0] lastSig,
  output logic [CNT_W-1:0] cntCorrect,
  output logic [CNT_W-1:0] cntViol,
  output logic [CNT_W-1:0] cntCrash,
  output logic             armed,
  output logic             waiting
);

  ctrlStrobes_t strobes;

  sigmon_ctrl #(.TO_W(TO_W), .SYNC_STAGES(2)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .portStrobe  (portStrobe),
    .timeoutLimit(timeoutLimit),
    .strobes     (strobes),
    .armed       (armed),
    .waiting     (waiting)
  );

  sigmon_dpath #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .portData  (portData),
    .expLoad   (expLoad),
    .expValue  (expValue),
    .outValid  (outValid),
    .outCode   (outCode),
    .lastSig   (lastSig),
    .cntCorrect(cntCorrect),
    .cntViol   (cntViol),
    .cntCrash  (cntCrash)
  );

endmodule

// File: rtl/sigmon_checker.sv
module sigmon_checker #(
  parameter int TO_W  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [TO_W-1:0]  timeoutLimit,
  input logic             outValid,
  input logic [1:0]       outCode,
  input logic [CNT_W-1:0] cntCorrect,
  input logic [CNT_W-1:0] cntViol,
  input logic [CNT_W-1:0] cntCrash,
  input logic             armed,
  input logic             waiting
);

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outCode == 2'b00); // R10

  AST_NO_OUTCOME_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !outValid); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (cntCorrect == '0 && cntViol == '0 && cntCrash == '0 && !outValid && armed)); // R2

  AST_JUDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outCode == 2'b01 || outCode == 2'b10)) |=>
      !(outValid && (outCode == 2'b01 || outCode == 2'b10))); // R3

  AST_CORRECT_CNT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(startPulse) && cntCorrect != $past(cntCorrect)) |-> (outValid && outCode == 2'b01)); // R4

  AST_VIOL_CNT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(startPulse) && cntViol != $past(cntViol)) |-> (outValid && outCode == 2'b10)); // R5

  AST_CRASH_CNT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(startPulse) && cntCrash != $past(cntCrash)) |-> (outValid && outCode == 2'b11)); // R6

  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> timeoutLimit != '0); // R6

  AST_CRASH_SETS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == 2'b11) |-> waiting); // R7

  AST_CRASH_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == 2'b11) |=> !(outValid && outCode == 2'b11)); // R7

  AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(startPulse) |-> (cntCorrect >= $past(cntCorrect) && cntViol >= $past(cntViol)
                            && cntCrash >= $past(cntCrash))); // R8

endmodule

bind result_sig_monitor sigmon_checker #(.TO_W(TO_W), .CNT_W(CNT_W)) u_sigmon_checker (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .timeoutLimit(timeoutLimit),
  .outValid    (outValid),
  .outCode     (outCode),
  .cntCorrect  (cntCorrect),
  .cntViol     (cntViol),
  .cntCrash    (cntCrash),
  .armed       (armed),
  .waiting     (waiting)
);

// File: tb/result_sig_monitor_bench.sv
module result_sig_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SIG_W = 16;
  localparam int TO_W  = 8;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic             expLoad = 1'b0;
  logic [SIG_W-1:0] expValue = '0;
  logic [TO_W-1:0]  timeoutLimit = 8'd40;
  logic             portStrobe = 1'b0;
  logic [SIG_W-1:0] portData = '0;
  logic             outValid;
  logic [1:0]       outCode;
  logic [SIG_W-1:0] lastSig;
  logic [CNT_W-1:0] cntCorrect, cntViol, cntCrash;
  logic             armed, waiting;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int mCorr = 0, mViol = 0, mCrash = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_sig_monitor #(.SIG_W(SIG_W), .TO_W(TO_W), .CNT_W(CNT_W)) u_result_sig_monitor (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .expLoad(expLoad), .expValue(expValue),
    .timeoutLimit(timeoutLimit), .portStrobe(portStrobe), .portData(portData),
    .outValid(outValid), .outCode(outCode), .lastSig(lastSig),
    .cntCorrect(cntCorrect), .cntViol(cntViol), .cntCrash(cntCrash),
    .armed(armed), .waiting(waiting)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chkCounters(input string req);
    chk(int'(cntCorrect) == mCorr, req, "cntCorrect", int'(cntCorrect), mCorr);
    chk(int'(cntViol) == mViol, req, "cntViol", int'(cntViol), mViol);
    chk(int'(cntCrash) == mCrash, req, "cntCrash", int'(cntCrash), mCrash);
  endtask

  task automatic doLoad(input logic [SIG_W-1:0] v);
    @(negedge clk); expLoad = 1'b1; expValue = v;
    @(negedge clk); expLoad = 1'b0;
  endtask

  // Start raised at one falling edge, dropped at the next
  task automatic doStart(input int lim);
    @(negedge clk); timeoutLimit = TO_W'(lim); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    mCorr = 0; mViol = 0; mCrash = 0;
  endtask

  // Raise strobe at falling edge Na; outcome expected visible at Na+3
  task automatic pulseStrobe(input logic [SIG_W-1:0] d,
                             output bit v0, output logic [1:0] c0,
                             output bit v1, output logic [1:0] c1,
                             output bit v2);
    @(negedge clk); portData = d; portStrobe = 1'b1;
    repeat (2) @(negedge clk);
    v0 = outValid; c0 = outCode;
    @(negedge clk);
    v1 = outValid; c1 = outCode;
    @(negedge clk);
    v2 = outValid;
    portStrobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendExpect(input logic [SIG_W-1:0] d, input bit match, input string req);
    bit v0, v1, v2;
    logic [1:0] c0, c1;
    pulseStrobe(d, v0, c0, v1, c1, v2);
    if (match) mCorr = sat(mCorr + 1); else mViol = sat(mViol + 1);
    chk(!v0, "R3", "outValid early", int'(v0), 0);
    chk(v1, "R3", "outValid on capture", int'(v1), 1);
    chk(!v2, "R3", "outValid one cycle", int'(v2), 0);
    chk(c1 == (match ? 2'b01 : 2'b10), req, "outCode", int'(c1), match ? 1 : 2);
    chk(lastSig == d, "R3", "lastSig", int'(lastSig), int'(d));
    chk(outCode == 2'b00, "R10", "idle outCode", int'(outCode), 0);
    chkCounters(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!outValid, "R1", "outValid", int'(outValid), 0);
    chk(outCode == 2'b00, "R1", "outCode", int'(outCode), 0);
    chk(!armed && !waiting, "R1", "armed/waiting", int'({armed, waiting}), 0);
    chkCounters("R1");

    // R2 strobe before start is ignored
    begin
      bit v0, v1, v2;
      logic [1:0] c0, c1;
      pulseStrobe(16'h1111, v0, c0, v1, c1, v2);
      chk(!(v0 || v1 || v2), "R2", "outcome before start", int'({v0, v1, v2}), 0);
      chkCounters("R2");
    end

    // Sweep: four expected values, match plus every single-bit error
    begin
      logic [SIG_W-1:0] prevE = '0;
      doLoad(16'h0000);
      doStart(40);
      chk(armed, "R2", "armed after start", int'(armed), 1);
      chkCounters("R2");
      for (int k = 0; k < 4; k++) begin
        logic [SIG_W-1:0] e;
        e = SIG_W'(k * 40503 + 7);
        doLoad(e);
        if (k > 0) sendExpect(prevE, 1'b0, "R9");
        sendExpect(e, 1'b1, "R4");
        for (int b = 0; b < SIG_W; b++) begin
          sendExpect(e ^ (SIG_W'(1) << b), 1'b0, (mViol >= CMAX) ? "R8" : "R5");
        end
        prevE = e;
      end
      chk(int'(cntViol) == CMAX, "R8", "cntViol saturated", int'(cntViol), CMAX);
    end

    // R6 timeout measured from the start edge; R2 restart clears counters
    begin
      int lim = 12;
      int waited;
      logic [SIG_W-1:0] e = 16'hBEEF;
      doLoad(e);
      doStart(lim);
      chkCounters("R2");
      waited = 1;
      while (!outValid && waited < 4 * lim) begin
        @(negedge clk); waited++;
      end
      mCrash = 1;
      chk(waited == lim + 1, "R6", "crash delay", waited, lim + 1);
      chk(outCode == 2'b11, "R6", "crash code", int'(outCode), 3);
      chk(waiting, "R7", "waiting after crash", int'(waiting), 1);
      chkCounters("R6");
      // R7 no repeat while paused
      begin
        bit seen = 1'b0;
        for (int i = 0; i < 3 * lim; i++) begin
          @(negedge clk);
          if (outValid) seen = 1'b1;
        end
        chk(!seen, "R7", "repeat crash", int'(seen), 0);
        chk(waiting, "R7", "still waiting", int'(waiting), 1);
        chkCounters("R7");
      end
      sendExpect(e, 1'b1, "R7");
      chk(!waiting, "R7", "waiting cleared", int'(waiting), 0);

      // R11 capture on the expiry edge wins
      begin
        bit v0, v1, v2;
        logic [1:0] c0, c1;
        doStart(lim);
        repeat (lim - 4) @(negedge clk);
        pulseStrobe(e, v0, c0, v1, c1, v2);
        chk(!v0 && v1 && c1 == 2'b01, "R11", "capture at expiry code", int'(c1), 1);
        chk(int'(cntCrash) == 0, "R11", "no crash counted", int'(cntCrash), 0);
        // one cycle later: crash first, then the late capture is judged
        doStart(lim);
        repeat (lim - 3) @(negedge clk);
        pulseStrobe(e ^ 16'h0100, v0, c0, v1, c1, v2);
        chk(v0 && c0 == 2'b11, "R6", "crash one edge before capture", int'(c0), 3);
        chk(v1 && c1 == 2'b10, "R7", "late capture judged", int'(c1), 2);
        chk(!waiting, "R7", "waiting cleared by capture", int'(waiting), 0);
        chk(int'(cntCrash) == 1 && int'(cntViol) == 1, "R7", "counts after late capture",
            int'(cntCrash) * 100 + int'(cntViol), 101);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule